// File: doc/BRIEF.md
# Quadrature Encoder Counter with Ceiling

This block counts events from two external pulse inputs. It has two modes. In plain counting mode it increments on a chosen edge of input A and ignores input B. In encoder mode it treats A and B as a quadrature pair and counts up or down. The direction depends on which input moved, which way it moved, and the level of the other input. Both inputs pass through two-flop synchronizers before any edge detection, so they may be fully asynchronous to the block clock.

The count runs from zero up to a programmable ceiling and wraps at either end; a wrap sets a sticky flag. Software drives the block through a small word-wide register port with these rules:
- Mode and edge selection may change only while the block is disabled.
- The ceiling and compare values may change only while it is enabled.
- Each accepted ceiling or compare write raises an acknowledge flag two clocks later. Software clears these flags through a write-one-to-clear register.
- Counting needs an enable bit and a separately set start bit.

Top module: `qenc_counter`

## Requirements
- R1: After reset the count reads 0, the ceiling reads all ones (0xFFFF), and the control, configuration, compare and status registers read 0. Register addresses: 0 control, 1 configuration, 2 ceiling, 3 compare, 4 count (read only), 5 status, 6 flag clear.
- R2: With configuration bit 0 (mode) at 0, the count rises by one on each selected edge of input A and never falls, and input B has no effect. The edge is selected by configuration bits [2:1]: 0 rising, 1 falling, 2 or 3 both.
- R3: With mode 1 and both edges selected, the count behaves as follows:
  - A rising: down if B is high, up if B is low.
  - A falling: up if B is high, down if B is low.
  - B rising: up if A is high, down if A is low.
  - B falling: down if A is high, up if A is low.
- R4: With mode 1 and edge select 0 (rising) or 1 (falling), only edges of that direction on A or B change the count, with the direction given in R3. Edges of the other direction do nothing.
- R5: In mode 1, a synchronized change on A and B in the same clock is discarded and leaves the count unchanged.
- R6: Counting up from a value at or above the ceiling gives 0, and counting down from 0 gives the ceiling. Either wrap sets the sticky status bit 2.
- R7: Writes to the ceiling or compare register while control bit 0 (enable) is 0 are ignored.
- R8: An accepted ceiling write sets status bit 0, and an accepted compare write sets status bit 1.
  - The flag becomes readable two clocks after the write edge.
  - Writing 1 to the same bit position of the clear register clears the flag, and a clear that meets a new set loses.
- R9: The count changes only while both enable (control bit 0) and start (control bit 1) are 1, and otherwise holds. Start can be set only by a control write made while enable is already 1. Writing enable 0 clears both bits.
- R10: Configuration writes made while enable is 1 are ignored.
- R11: The count register may be read at any time, and reading it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enc_a | input | 1 | Pulse input A, asynchronous |
| enc_b | input | 1 | Pulse input B, asynchronous |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW (3) | Register address for read and write |
| bus_wdata | input | W (16) | Write data |
| bus_rdata | output | W (16) | Read data for bus_addr, combinational |

## Verification
The hardest condition to reach from the ports is a wrap in each direction under every edge selection in encoder mode. With the default ceiling this needs tens of thousands of edges. The stimulus therefore first programs a ceiling of 5, which is legal only while enabled. It then disables, reconfigures and restarts the block through the required write order for each mode. After that it feeds long random walks of single-input toggles, plus occasional simultaneous A/B toggles. Each toggle is followed by a settle time longer than the synchronizer path, so a bench model can track every step.

// File: rtl/qenc_counter.sv
module qenc_counter #(
  parameter int W  = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enc_a,
  input  logic          enc_b,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata
);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_CFG  = AW'(1);
  localparam logic [AW-1:0] A_CEIL = AW'(2);
  localparam logic [AW-1:0] A_CMP  = AW'(3);
  localparam logic [AW-1:0] A_CNT  = AW'(4);
  localparam logic [AW-1:0] A_STAT = AW'(5);
  localparam logic [AW-1:0] A_CLR  = AW'(6);

  logic         en_q, start_q, mode_q;
  logic [1:0]   edge_q;
  logic [W-1:0] ceil_q, cmp_q, cnt_q;
  logic         ceil_ok_q, cmp_ok_q, wrap_q;
  logic [1:0]   ceil_p, cmp_p;
  logic [2:0]   a_sh, b_sh;

  wire wr_ctrl = bus_wr && bus_addr == A_CTRL;
  wire wr_cfg  = bus_wr && bus_addr == A_CFG && !en_q;
  wire wr_ceil = bus_wr && bus_addr == A_CEIL && en_q;
  wire wr_cmp  = bus_wr && bus_addr == A_CMP && en_q;
  wire wr_clr  = bus_wr && bus_addr == A_CLR;
  wire run     = en_q && start_q;

  wire a_now = a_sh[1];
  wire b_now = b_sh[1];
  wire a_chg = a_sh[1] ^ a_sh[2];
  wire b_chg = b_sh[1] ^ b_sh[2];
  wire take_rise = edge_q != 2'd1;
  wire take_fall = edge_q != 2'd0;
  wire a_act = a_chg && (a_now ? take_rise : take_fall);
  wire b_act = b_chg && (b_now ? take_rise : take_fall);

  logic step, up;
  always_comb begin
    step = 1'b0;
    up   = 1'b1;
    if (!mode_q) begin
      step = a_act;
    end else if (!(a_chg && b_chg)) begin
      if (a_act) begin
        step = 1'b1;
        up   = a_now ^ b_now;
      end else if (b_act) begin
        step = 1'b1;
        up   = ~(a_now ^ b_now);
      end
    end
  end

  wire          wrap_up = up && cnt_q >= ceil_q;
  wire          wrap_dn = !up && cnt_q == '0;
  wire          wrap_ev = run && step && (wrap_up || wrap_dn);
  wire [W-1:0]  cnt_nx  = up ? (wrap_up ? '0 : cnt_q + 1'b1)
                             : (wrap_dn ? ceil_q : cnt_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_sh <= '0;
      b_sh <= '0;
    end else begin
      a_sh <= {a_sh[1:0], enc_a};
      b_sh <= {b_sh[1:0], enc_b};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      start_q <= 1'b0;
      mode_q  <= 1'b0;
      edge_q  <= 2'd0;
      ceil_q  <= '1;
      cmp_q   <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q    <= bus_wdata[0];
        start_q <= bus_wdata[0] && (start_q || (en_q && bus_wdata[1]));
      end
      if (wr_cfg) begin
        mode_q <= bus_wdata[0];
        edge_q <= bus_wdata[2:1];
      end
      if (wr_ceil) ceil_q <= bus_wdata;
      if (wr_cmp)  cmp_q  <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (run && step) begin
      cnt_q <= cnt_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ceil_p    <= '0;
      cmp_p     <= '0;
      ceil_ok_q <= 1'b0;
      cmp_ok_q  <= 1'b0;
      wrap_q    <= 1'b0;
    end else begin
      ceil_p    <= {ceil_p[0], wr_ceil};
      cmp_p     <= {cmp_p[0], wr_cmp};
      ceil_ok_q <= ceil_p[1] || (ceil_ok_q && !(wr_clr && bus_wdata[0]));
      cmp_ok_q  <= cmp_p[1]  || (cmp_ok_q  && !(wr_clr && bus_wdata[1]));
      wrap_q    <= wrap_ev   || (wrap_q    && !(wr_clr && bus_wdata[2]));
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: bus_rdata[1:0] = {start_q, en_q};
      A_CFG:  bus_rdata[2:0] = {edge_q, mode_q};
      A_CEIL: bus_rdata      = ceil_q;
      A_CMP:  bus_rdata      = cmp_q;
      A_CNT:  bus_rdata      = cnt_q;
      A_STAT: bus_rdata[2:0] = {wrap_q, cmp_ok_q, ceil_ok_q};
      default: bus_rdata     = '0;
    endcase
  end
endmodule

module qenc_counter_chk #(
  parameter int W  = 16,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic          en,
  input logic          start,
  input logic          mode,
  input logic [1:0]    edge_sel,
  input logic [W-1:0]  ceil,
  input logic [W-1:0]  cnt,
  input logic          ceil_ok
);
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && start) |=> $stable(cnt));

  // R9
  start_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !start);

  // R7
  ceil_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(2) && !en) |=> $stable(ceil));

  // R8
  ceil_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(2) && en) |=> ##2 ceil_ok);

  // R10
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> ($stable(mode) && $stable(edge_sel)));

  // R2
  no_decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !mode) |=> (cnt == $past(cnt) || cnt == W'($past(cnt) + 1'b1) || cnt == '0));
endmodule

bind qenc_counter qenc_counter_chk #(.W(W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .en(en_q), .start(start_q), .mode(mode_q), .edge_sel(edge_q),
  .ceil(ceil_q), .cnt(cnt_q), .ceil_ok(ceil_ok_q)
);

// File: tb/sim_qenc_counter.sv
module sim_qenc_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enc_a = 1'b0, enc_b = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;

  int checks = 0;
  int fails = 0;
  logic [15:0] m_cnt = '0, m_ceil = 16'hFFFF, d, d2;
  bit m_mode = 0, m_run = 0, m_wrap = 0;
  logic [1:0] m_sel = 2'd0;

  always #5 clk = ~clk;

  qenc_counter u0 (.clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] v);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  function automatic bit edge_ok(bit rising);
    return rising ? (m_sel != 2'd1) : (m_sel != 2'd0);
  endfunction

  function automatic void model(bit ta, bit tb, bit na, bit nb);
    bit go = 0, up = 1;
    if (!m_mode) begin
      go = ta && edge_ok(na);
    end else if (!(ta && tb)) begin
      if (ta && edge_ok(na)) begin
        go = 1;
        up = na ? !nb : nb;
      end else if (tb && edge_ok(nb)) begin
        go = 1;
        up = nb ? na : !na;
      end
    end
    if (go && m_run) begin
      if (up) begin
        if (m_cnt >= m_ceil) begin m_cnt = '0; m_wrap = 1; end
        else m_cnt = m_cnt + 1'b1;
      end else begin
        if (m_cnt == '0) begin m_cnt = m_ceil; m_wrap = 1; end
        else m_cnt = m_cnt - 1'b1;
      end
    end
  endfunction

  task automatic toggle(bit ta, bit tb, string req);
    @(negedge clk);
    if (ta) enc_a = ~enc_a;
    if (tb) enc_b = ~enc_b;
    repeat (4) @(negedge clk);
    model(ta, tb, enc_a, enc_b);
    rd(3'd4, d);
    chk(req, d, m_cnt);
  endtask

  task automatic walk(int n, string req);
    for (int i = 0; i < n; i++) begin
      int r = $urandom % 8;
      if (r == 6 && m_mode) toggle(1, 1, "R5");
      else if (r >= 3 && r <= 5) toggle(0, 1, req);
      else toggle(1, 0, req);
    end
    rd(3'd5, d);
    chk("R6 wrap flag", {13'd0, d[2], 2'd0}, {13'd0, m_wrap, 2'd0});
    wr(3'd6, 16'h4);
    m_wrap = 0;
    rd(3'd5, d);
    chk("R6 wrap clear", {13'd0, d[2], 2'd0}, 16'd0);
  endtask

  task automatic reconfig(bit mode, logic [1:0] sel, string req);
    wr(3'd0, 16'd0);
    wr(3'd1, {13'd0, sel, mode});
    rd(3'd1, d);
    chk("R10 cfg while disabled", d, {13'd0, sel, mode});
    m_mode = mode; m_sel = sel; m_run = 0;
    wr(3'd0, 16'd1);
    wr(3'd0, 16'd3);
    m_run = 1;
    walk(60, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    d = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(3'd4, d); chk("R1 count", d, 16'd0);
    rd(3'd2, d); chk("R1 ceiling", d, 16'hFFFF);
    rd(3'd0, d); chk("R1 control", d, 16'd0);
    rd(3'd1, d); chk("R1 config", d, 16'd0);
    rd(3'd3, d); chk("R1 compare", d, 16'd0);
    rd(3'd5, d); chk("R1 status", d, 16'd0);

    wr(3'd2, 16'd100);
    wr(3'd3, 16'd7);
    repeat (3) @(negedge clk);
    rd(3'd2, d); chk("R7 ceiling locked", d, 16'hFFFF);
    rd(3'd3, d); chk("R7 compare locked", d, 16'd0);
    rd(3'd5, d); chk("R7 no ack", d, 16'd0);

    wr(3'd0, 16'd2);
    rd(3'd0, d); chk("R9 start needs enable", d, 16'd0);
    wr(3'd0, 16'd1);
    rd(3'd0, d); chk("R9 enabled only", d, 16'd1);
    toggle(1, 0, "R9 not started");
    toggle(1, 0, "R9 not started");
    wr(3'd0, 16'd3);
    rd(3'd0, d); chk("R9 started", d, 16'd3);
    m_run = 1;
    walk(40, "R2 rising");

    wr(3'd1, 16'd5);
    rd(3'd1, d); chk("R10 cfg ignored", d, 16'd0);

    wr(3'd2, 16'd5);
    rd(3'd5, d); chk("R8 ceil ack early", {15'd0, d[0]}, 16'd0);
    @(negedge clk); rd(3'd5, d); chk("R8 ceil ack early", {15'd0, d[0]}, 16'd0);
    @(negedge clk); rd(3'd5, d); chk("R8 ceil ack", {15'd0, d[0]}, 16'd1);
    m_ceil = 16'd5;
    rd(3'd2, d); chk("R7 ceiling accepted", d, 16'd5);
    wr(3'd6, 16'd1);
    rd(3'd5, d); chk("R8 ceil ack cleared", {15'd0, d[0]}, 16'd0);
    wr(3'd3, 16'd9);
    repeat (2) @(negedge clk);
    rd(3'd5, d); chk("R8 cmp ack", {14'd0, d[1], 1'b0}, 16'd2);
    rd(3'd3, d); chk("R7 compare accepted", d, 16'd9);
    wr(3'd6, 16'd2);
    rd(3'd5, d); chk("R8 cmp ack cleared", {14'd0, d[1], 1'b0}, 16'd0);

    walk(30, "R6 counter wrap");

    wr(3'd0, 16'd0);
    rd(3'd0, d); chk("R9 disable clears start", d, 16'd0);
    m_run = 0;
    toggle(1, 0, "R9 hold");
    toggle(1, 0, "R9 hold");
    rd(3'd4, d); rd(3'd4, d2); chk("R11 read no side effect", d2, d);

    reconfig(1, 2'd2, "R3 both edges");
    reconfig(1, 2'd0, "R4 rising only");
    reconfig(1, 2'd1, "R4 falling only");
    reconfig(0, 2'd1, "R2 falling");
    reconfig(0, 2'd2, "R2 both");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule